// File: doc/BRIEF.md
# Maskable Interrupt Collector with Pending Buffer

This block gathers a set of single-cycle event pulses from neighbouring logic into a request register that a host can read. Each source owns one bit. A writable enable mask decides which recorded bits may pull the shared interrupt line low. A masked bit is still recorded, so the host can poll for it. No source takes precedence over another: every bit is recorded and cleared on the same terms, and sorting out priority is left to software.

The host reads the request register with a one-cycle read strobe. The value returned in that cycle is the register's contents, and the register then empties. An event that lands in the same cycle as the strobe is not lost. It is parked in a hidden holding register and merged into the request register on the first cycle with no strobe. So the interrupt line can drop back low right after a read clears it. The interrupt line is given both as an active-low level and as an output-enable for an open-drain pad.

The host-side path is a plain register strobe, not a stream. It has no valid/ready pair and no back-pressure: every strobe is accepted in the cycle it is seen, and a read completes in that same cycle.

Top module: `irq_pending_ctrl`

## Requirements
- R1: After reset, the request register, the mask and the hidden holding register are all zero, `irq_oe_o` is 0 and `irq_no` is 1.
- R2: An event bit seen in a cycle with no read strobe sets the matching request bit, visible from the next cycle. A set bit stays set until a read.
- R3: An event on a masked source (mask bit 0) is still recorded in the request register, but it does not assert the interrupt line.
- R4: A mask write loads `mask_wdata_i` into the mask, visible on `mask_o` from the next cycle. Mask bit value 1 enables a source and 0 masks it.
- R5: During a read-strobe cycle, `req_rdata_o` shows the request register's current contents. From the next cycle the register reads zero.
- R6: An event that arrives in a read-strobe cycle does not appear in the cycle right after the read. It appears in the cycle after the first following cycle with no strobe.
- R7: Held events survive back-to-back read strobes. They are merged only when a cycle without a strobe occurs.
- R8: If a held event is unmasked, the interrupt line goes high for exactly one cycle after the read and then goes low again.
- R9: There is no priority among sources. Any mix of simultaneous events is recorded bit for bit.
- R10: `irq_oe_o` is 1 exactly when some request bit and its mask bit are both 1, and `irq_no` is always the inverse of `irq_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| event_i | input | 8 | Single-cycle event pulses, one per source |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask value to write |
| req_rd_i | input | 1 | Request register read strobe (clears on read) |
| req_rdata_o | output | 8 | Current request register contents |
| mask_o | output | 8 | Current mask contents |
| irq_oe_o | output | 1 | Pad pull-down enable for the open-drain interrupt line |
| irq_no | output | 1 | Active-low interrupt level |

## Verification
Results are due at different times:
- A recorded event or a new mask value shows up one clock edge after its stimulus.
- The read data is valid in the same cycle as the strobe.
- An event that coincides with a strobe becomes visible two edges later.
- The interrupt outputs follow the registered state with no added delay.

The bench drives inputs on the falling edge. It reads the read data just before the rising edge that consumes the strobe. It compares all other outputs on the next falling edge against a reference model in the bench, which it advances once per rising edge. The directed sequences for the held-event cases check the cycle right after the read and the cycle after that, so a one-cycle slip in either direction is caught.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int unsigned IC_NUM_SRC = 8;

  typedef enum logic [0:0] {
    CAP_ACCUM = 1'b0,
    CAP_CLEAR = 1'b1
  } cap_op_e;
endpackage

// File: rtl/ic_capture.sv
module ic_capture #(
  parameter int unsigned NUM_SRC = ic_pkg::IC_NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               rd_i,
  output logic [NUM_SRC-1:0] req_o
);
  import ic_pkg::*;

  cap_op_e op;

  always_comb begin
    op = rd_i ? CAP_CLEAR : CAP_ACCUM;
  end

  // One request bit and one hidden holding bit per source; no cross-bit logic.
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    logic req_q;
    logic hold_q;

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        req_q  <= 1'b0;
        hold_q <= 1'b0;
      end else if (op == CAP_CLEAR) begin
        req_q  <= 1'b0;
        hold_q <= hold_q | event_i[b];
      end else begin
        req_q  <= req_q | event_i[b] | hold_q;
        hold_q <= 1'b0;
      end
    end

    assign req_o[b] = req_q;
  end
endmodule

// File: rtl/ic_mask_reg.sv
module ic_mask_reg #(
  parameter int unsigned NUM_SRC = ic_pkg::IC_NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (we_i) begin
      mask_q <= wdata_i;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/ic_irq_drive.sv
module ic_irq_drive #(
  parameter int unsigned NUM_SRC = ic_pkg::IC_NUM_SRC
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               oe_o,
  output logic               irq_no
);
  logic [NUM_SRC-1:0] live;

  always_comb begin
    live   = req_i & mask_i;
    oe_o   = |live;
    irq_no = ~oe_o;
  end
endmodule

// File: rtl/irq_pending_ctrl.sv
module irq_pending_ctrl #(
  parameter int unsigned NUM_SRC = ic_pkg::IC_NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic               req_rd_i,
  output logic [NUM_SRC-1:0] req_rdata_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_oe_o,
  output logic               irq_no
);
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] mask;

  ic_capture #(.NUM_SRC(NUM_SRC)) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .event_i(event_i),
    .rd_i   (req_rd_i),
    .req_o  (req)
  );

  ic_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we_i),
    .wdata_i(mask_wdata_i),
    .mask_o (mask)
  );

  ic_irq_drive #(.NUM_SRC(NUM_SRC)) u_drive (
    .req_i (req),
    .mask_i(mask),
    .oe_o  (irq_oe_o),
    .irq_no(irq_no)
  );

  assign req_rdata_o = req;
  assign mask_o      = mask;
endmodule

// File: rtl/irq_pending_ctrl_chk.sv
module irq_pending_ctrl_chk #(
  parameter int unsigned NUM_SRC = ic_pkg::IC_NUM_SRC
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] event_i,
  input logic               mask_we_i,
  input logic [NUM_SRC-1:0] mask_wdata_i,
  input logic               req_rd_i,
  input logic [NUM_SRC-1:0] req_rdata_o,
  input logic [NUM_SRC-1:0] mask_o,
  input logic               irq_oe_o,
  input logic               irq_no
);
  // Set once the first clock edge with reset released has occurred.
  logic live_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  p_clear_on_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_rd_i |=> (req_rdata_o == '0));

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !req_rd_i) |=> ((req_rdata_o & $past(req_rdata_o)) == $past(req_rdata_o)));

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_rd_i |=> ((req_rdata_o & $past(event_i)) == $past(event_i)));

  p_mask_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_o == $past(mask_wdata_i)));

  p_mask_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !mask_we_i) |=> $stable(mask_o));

  p_polarity_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !irq_oe_o);

  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_rdata_o & mask_o) == '0) |-> irq_no);
endmodule

bind irq_pending_ctrl irq_pending_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/test_irq_pending_ctrl.sv
module test_irq_pending_ctrl;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic         mwe = 1'b0;
  logic [N-1:0] mwd = '0;
  logic         rd = 1'b0;
  logic [N-1:0] rdata;
  logic [N-1:0] mask;
  logic         oe;
  logic         irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  logic [N-1:0] m_req = '0;
  logic [N-1:0] m_hold = '0;
  logic [N-1:0] m_mask = '0;

  always #10 clk = ~clk;

  irq_pending_ctrl #(.NUM_SRC(N)) i_irq_pending_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .event_i(evt), .mask_we_i(mwe),
    .mask_wdata_i(mwd), .req_rd_i(rd), .req_rdata_o(rdata),
    .mask_o(mask), .irq_oe_o(oe), .irq_no(irq_n)
  );

  function automatic logic exp_oe(input logic [N-1:0] r, input logic [N-1:0] m);
    return |(r & m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model update from the requirements (R2, R5, R6, R7, R4).
  task automatic model_edge();
    if (mwe) m_mask = mwd;
    if (rd) begin
      m_hold = m_hold | evt;
      m_req  = '0;
    end else begin
      m_req  = m_req | evt | m_hold;
      m_hold = '0;
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " req"}, rdata, m_req);
    chk({tag, " mask"}, mask, m_mask);
    chk({tag, " oe R10"}, oe, exp_oe(m_req, m_mask));
    chk({tag, " irq_n R10"}, irq_n, !exp_oe(m_req, m_mask));
  endtask

  // Drive one cycle at the falling edge, consume it at the rising edge,
  // and compare at the next falling edge.
  task automatic cyc(input logic [N-1:0] e, input logic r, input logic w,
                     input logic [N-1:0] wd, input string tag);
    evt = e; rd = r; mwe = w; mwd = wd;
    #1;
    if (r) chk({tag, " read data R5"}, rdata, m_req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    evt = '0; rd = 1'b0; mwe = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    chk("R1 oe", oe, 1'b0);
    chk("R1 irq_n", irq_n, 1'b1);

    // R3: masked event recorded, line stays high
    cyc(8'h10, 1'b0, 1'b0, '0, "R3 masked");
    chk("R3 irq high", irq_n, 1'b1);
    chk("R3 recorded", rdata, 8'h10);

    // R4: enable mask bit 4, irq falls
    cyc('0, 1'b0, 1'b1, 8'h10, "R4 mask");
    chk("R4 irq low", irq_n, 1'b0);

    // R9: several simultaneous events
    cyc(8'hA5, 1'b0, 1'b0, '0, "R9 multi");
    chk("R9 bits", rdata, 8'hB5);

    // R5: read clears
    cyc('0, 1'b1, 1'b1, 8'hFF, "R5 read");
    chk("R5 cleared", rdata, 8'h00);

    // R6/R8: event coincident with read
    cyc(8'h01, 1'b0, 1'b0, '0, "R6 setup");
    cyc(8'h04, 1'b1, 1'b0, '0, "R6 read");
    chk("R6 absent", rdata, 8'h00);
    chk("R8 high one cycle", irq_n, 1'b1);
    cyc('0, 1'b0, 1'b0, '0, "R6 merge");
    chk("R6 present", rdata, 8'h04);
    chk("R8 low again", irq_n, 1'b0);

    // R7: back-to-back reads keep held events
    cyc(8'h40, 1'b1, 1'b0, '0, "R7 rd1");
    cyc(8'h02, 1'b1, 1'b0, '0, "R7 rd2");
    chk("R7 still empty", rdata, 8'h00);
    cyc('0, 1'b0, 1'b0, '0, "R7 merge");
    chk("R7 both held", rdata, 8'h42);

    // Random traffic against the model (R2, R5, R6, R9)
    for (int i = 0; i < 2000; i++) begin
      logic [N-1:0] e;
      logic r, w;
      e = (($urandom % 4) == 0) ? N'($urandom) : '0;
      r = (($urandom % 5) == 0);
      w = (($urandom % 16) == 0);
      cyc(e, r, w, N'($urandom), "R2 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule